// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block multiplies or divides two 32-bit operands over a fixed run of clock cycles. Multiplication and division share one adder and one shift register. A multiply adds the multiplicand into the upper half of the register when the current multiplier bit is set, and shifts the register right in the same step. A divide shifts the register left and tries to subtract the divisor. When the trial result would go below zero, the old value is kept and a quotient bit of 0 enters. Otherwise the difference is kept and a quotient bit of 1 enters.

Signed operations run on the operand magnitudes. A sign correction is applied as the result is written. The result goes into two 32-bit registers, HI and LO, which keep their value until the next operation finishes. The unit raises no overflow indication and no divide-by-zero indication. A zero divisor still produces a fixed, well-defined result.

A client checks that `busy` is low, then pulses `start` for one cycle with an opcode and two operands. It waits for the one-cycle `done` pulse and then reads `hi` and `lo`.

Top module: `muldiv_hilo`

## Requirements
- R1: A `start` sampled high while `busy` is low accepts the operation. `op` selects it: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R2: An unsigned multiply leaves the full 64-bit product in {hi, lo}: upper 32 bits in `hi`, lower 32 bits in `lo`.
- R3: A signed multiply leaves the 64-bit two's-complement product in {hi, lo}. This includes operands of 32'h80000000.
- R4: An unsigned divide with a nonzero divisor leaves the quotient in `lo` and the remainder in `hi`.
- R5: A signed divide with a nonzero divisor truncates the quotient toward zero, and the remainder takes the sign of the dividend. 32'h80000000 divided by -1 gives lo = 32'h80000000 and hi = 0, with no other indication.
- R6: A divide by zero, signed or unsigned, gives lo = 32'hFFFFFFFF and hi equal to the dividend.
- R7: `busy` is high from the cycle after the accepting edge. The 32nd clock edge after the accepting edge clears `busy`, raises `done` for exactly one cycle, and updates `hi`/`lo`.
- R8: A `start` while `busy` is high is ignored. The running operation finishes with its own result, and no extra `done` appears.
- R9: `hi` and `lo` change only at the edge that raises `done`, and hold otherwise.
- R10: After reset, `hi`, `lo`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| op | input | 2 | Operation select (R1 encoding) |
| a | input | 32 | Multiplicand or dividend |
| b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Product upper half or remainder |
| lo | output | 32 | Product lower half or quotient |

## Verification
Internal state is visible only at the `done` edge, because `hi`/`lo` are written only there. A single wrong add, restore or shift during the 32 iterations therefore shows up as a wrong value in the one result it belongs to. That error appears exactly 32 edges after the start, and no earlier port gives a hint of it. An off-by-one in the iteration count shifts the `done` pulse in time, so every result's arrival cycle is measured against its start. A lost sign flag or divisor-zero flag corrupts only signed or zero-divisor cases. For that reason, operands of mixed sign, the most negative value and a zero divisor are all driven.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic           run, fin, is_div, neg_p, neg_r;
  logic [CW-1:0]  cnt;
  logic [W:0]     acc;
  logic [W-1:0]   qr, opnd, hi_q, lo_q;

  wire            take  = start && !run;
  wire            a_neg = !op[0] && a[W-1];
  wire            b_neg = !op[0] && b[W-1];
  wire [W-1:0]    a_mag = a_neg ? -a : a;
  wire [W-1:0]    b_mag = b_neg ? -b : b;

  logic [W:0]     add_x, add_y, nx_acc;
  logic [W+1:0]   sum;
  logic [W-1:0]   nx_qr;

  always_comb begin
    if (is_div) begin
      add_x = {acc[W-1:0], qr[W-1]};
      add_y = ~{1'b0, opnd};
    end else begin
      add_x = {1'b0, acc[W-1:0]};
      add_y = qr[0] ? {1'b0, opnd} : '0;
    end
    sum = {1'b0, add_x} + {is_div, add_y} + {{(W+1){1'b0}}, is_div};
    if (is_div) begin
      nx_acc = sum[W+1] ? add_x : sum[W:0];
      nx_qr  = {qr[W-2:0], ~sum[W+1]};
    end else begin
      nx_acc = {1'b0, sum[W:1]};
      nx_qr  = {sum[0], qr[W-1:1]};
    end
  end

  wire [2*W-1:0] prod     = {nx_acc[W-1:0], nx_qr};
  wire [2*W-1:0] prod_fix = neg_p ? -prod : prod;
  wire [W-1:0]   quo_fix  = neg_p ? -nx_qr : nx_qr;
  wire [W-1:0]   rem_fix  = neg_r ? -nx_acc[W-1:0] : nx_acc[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; fin <= 1'b0; cnt <= '0; is_div <= 1'b0;
      neg_p <= 1'b0; neg_r <= 1'b0;
      acc <= '0; qr <= '0; opnd <= '0; hi_q <= '0; lo_q <= '0;
    end else begin
      fin <= 1'b0;
      if (run) begin
        acc <= nx_acc;
        qr  <= nx_qr;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
          if (is_div) begin
            hi_q <= rem_fix;
            lo_q <= quo_fix;
          end else begin
            hi_q <= prod_fix[2*W-1:W];
            lo_q <= prod_fix[W-1:0];
          end
        end
      end else if (take) begin
        run    <= 1'b1;
        cnt    <= '0;
        is_div <= op[1];
        acc    <= '0;
        qr     <= op[1] ? a_mag : b_mag;
        opnd   <= op[1] ? b_mag : a_mag;
        neg_p  <= (a_neg ^ b_neg) && !(op[1] && b == '0);
        neg_r  <= op[1] && a_neg;
      end
    end
  end

  assign busy = run;
  assign done = fin;
  assign hi   = hi_q;
  assign lo   = lo_q;

  logic [CW+1:0] span;
  always_ff @(posedge clk) begin
    if (!rst_n)    span <= '0;
    else if (take) span <= '0;
    else if (run)  span <= span + 1'b1;
  end

  // R7
  done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_w_edges: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> span == (CW+2)'(W));
  // R7
  busy_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R1
  idle_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R8
  busy_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && span != (CW+2)'(W - 1)) |=> busy && !done);
  // R9
  result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hi) && $stable(lo));
endmodule

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  muldiv_hilo dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
                   .busy(busy), .done(done), .hi(hi), .lo(lo));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [95:0] sb[$];
  logic [31:0] last_hi = '0, last_lo = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, q, m;
    logic [63:0] r;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      2'b00: r = 64'(sx * sy);
      2'b01: r = {32'b0, x} * {32'b0, y};
      2'b10: if (y == 0) r = {x, 32'hFFFFFFFF};
             else begin q = sx / sy; m = sx % sy; r = {m[31:0], q[31:0]}; end
      default: if (y == 0) r = {x, 32'hFFFFFFFF};
               else r = {x % y, x / y};
    endcase
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected done", {hi, lo}, 64'h0);
      end else begin
        logic [95:0] it;
        it = sb.pop_front();
        chk({hi, lo} == it[95:32], "R2/R3/R4/R5/R6 result", {hi, lo}, it[95:32]);
        chk(cyc == int'(it[31:0]) + 33, "R7 done latency", 64'(cyc), 64'(int'(it[31:0]) + 33));
        chk(!busy, "R7 busy low with done", 64'(busy), 64'h0);
        last_hi = hi;
        last_lo = lo;
      end
    end
  end

  task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                       input bit poke, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    sb.push_back({ref_op(o, x, y), 32'(cyc)});
    @(negedge clk);
    start = 1'b0;
    chk(busy, {"R1 busy after start ", tag}, 64'(busy), 64'h1);
    repeat (5) @(negedge clk);
    chk({hi, lo} == {last_hi, last_lo}, "R9 hold during run", {hi, lo}, {last_hi, last_lo});
    if (poke) begin
      op = ~o; a = 32'h1234_5678; b = 32'h0000_0003; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done, "R8 start while busy", {62'b0, busy, done}, 64'h2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hi, lo} == 64'h0 && !busy && !done, "R10 reset state", {hi, lo}, 64'h0);

    issue(2'b01, 32'd7, 32'd6, 1'b0, "R2 small");
    issue(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R2 max");
    issue(2'b00, 32'hFFFFFFFD, 32'd5, 1'b0, "R3 mixed");
    issue(2'b00, 32'h80000000, 32'h80000000, 1'b0, "R3 minneg");
    issue(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R3 neg neg");
    issue(2'b00, 32'h0, 32'h89ABCDEF, 1'b0, "R3 zero");
    issue(2'b11, 32'd100, 32'd7, 1'b0, "R4 small");
    issue(2'b11, 32'hFFFFFFFF, 32'd1, 1'b0, "R4 by one");
    issue(2'b11, 32'h9000_0001, 32'h8000_0000, 1'b0, "R4 big divisor");
    issue(2'b10, 32'hFFFFFFF9, 32'd2, 1'b0, "R5 neg dividend");
    issue(2'b10, 32'd7, 32'hFFFFFFFE, 1'b0, "R5 neg divisor");
    issue(2'b10, 32'h80000000, 32'hFFFFFFFF, 1'b0, "R5 overflow");
    issue(2'b11, 32'hDEADBEEF, 32'h0, 1'b0, "R6 unsigned zero");
    issue(2'b10, 32'hFFFFFFF7, 32'h0, 1'b0, "R6 signed zero");
    issue(2'b01, 32'h0001_0003, 32'h0002_0005, 1'b1, "R8 poke mul");
    issue(2'b10, 32'hFFFF_0000, 32'd9, 1'b1, "R8 poke div");

    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(!busy && !done, "R8 idle after last", {62'b0, busy, done}, 64'h0);
    chk({hi, lo} == {last_hi, last_lo}, "R9 hold when idle", {hi, lo}, {last_hi, last_lo});
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule